// File: doc/BRIEF.md
# Font Bitmap to Color Expander

This block sits on a simple 16-bit register bus and turns one-bit-per-pixel glyph data into four-bit-per-pixel color words. Software loads a 16-bit glyph pattern and an 8-bit palette byte. The palette byte holds two colors: the foreground color in its upper nibble and the background color in its lower nibble. Software then reads four result words, one after another. Each result word carries four expanded pixels, and each pixel takes the foreground or the background color according to its glyph bit.

The result words are formed combinationally from the two stored registers. A read therefore reflects the latest write with no added latency. Reads can be word wide, or byte wide with the address LSB choosing the half. The result locations are read-only.

Top module: `font_color_expander`

## Requirements
- R1: After reset, the palette register (word offset 0x4C) and the glyph register (word offset 0x4E) both read back as 16'h0000.
- R2: A word write to offset 0x4C stores busWrData[7:0] as the palette byte. The upper eight data bits are discarded, and a word read of 0x4C returns {8'h00, palette}.
- R3: A word write to offset 0x4E stores all 16 data bits as the glyph pattern, and a word read of 0x4E returns that pattern.
- R4: Result offsets 0x50, 0x52, 0x54 and 0x56 take their four glyph bits from bits 15..12, 11..8, 7..4 and 3..0 of the glyph register, in that order.
- R5: Within a result word, bit n of the selected group sets result bits 4n+3..4n. A set bit yields palette[7:4] and a clear bit yields palette[3:0].
- R6: While busRdByte is 1, busRdData[15:8] reads zero. busRdData[7:0] carries the upper byte of the addressed word for an even address and the lower byte for an odd address.
- R7: Writes to the result offsets 0x50–0x57 change neither register.
- R8: A read issued in the cycle after a write already returns data derived from the newly written values.
- R9: Reads from any unmapped offset return zero, and writes to unmapped offsets change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte offset of the access |
| busWrEn | input | 1 | Word write strobe, sampled on the rising clock edge |
| busWrData | input | 16 | Write data |
| busRdByte | input | 1 | 1 selects a byte read, 0 a word read |
| busRdData | output | 16 | Combinational read data |

## Verification
The bench goes after bit ordering inside a result word. A design that reversed the pixel order, or that took its groups from the wrong end of the glyph word, would fail the asymmetric vectors such as a single walking bit or the pattern 16'h1E6B. A swap of the two palette nibbles would show up at once with the all-ones and all-zeros glyphs. Byte reads on even and odd addresses expose a swapped half. Writes aimed at the result window and at unmapped space, each followed by a read-back of both registers, catch a decoder that lets those writes through.

// File: rtl/fce_pkg.sv
package fce_pkg;
  localparam int DATA_W       = 16;
  localparam int CODE_W       = 8;
  localparam int PIX_W        = 4;
  localparam int PIX_PER_WORD = DATA_W / PIX_W;
  localparam int GROUPS       = DATA_W / PIX_PER_WORD;
  localparam int IDX_W        = $clog2(GROUPS);

  typedef struct packed {
    logic             wrCode;
    logic             wrFont;
    logic             rdCode;
    logic             rdFont;
    logic             rdResult;
    logic [IDX_W-1:0] resIdx;
    logic             byteRd;
    logic             byteLow;
  } fceStrobes_t;
endpackage

// File: rtl/fce_ctrl.sv
module fce_ctrl
  import fce_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CODE_OFS = 8'h4C,
  parameter logic [ADDR_W-1:0] FONT_OFS = 8'h4E,
  parameter logic [ADDR_W-1:0] RES_BASE = 8'h50
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdByte,
  output fceStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] RES_END = RES_BASE + ADDR_W'(2 * GROUPS);

  logic [ADDR_W-1:0] wordAddr;
  logic [ADDR_W-1:0] resOfs;
  logic              inResult;

  always_comb begin
    wordAddr = {busAddr[ADDR_W-1:1], 1'b0};
    resOfs   = wordAddr - RES_BASE;
    inResult = (wordAddr >= RES_BASE) && (wordAddr < RES_END);

    strobes          = '0;
    strobes.rdCode   = (wordAddr == CODE_OFS);
    strobes.rdFont   = (wordAddr == FONT_OFS);
    strobes.rdResult = inResult;
    strobes.resIdx   = resOfs[IDX_W:1];
    strobes.wrCode   = busWrEn && (wordAddr == CODE_OFS);
    strobes.wrFont   = busWrEn && (wordAddr == FONT_OFS);
    strobes.byteRd   = busRdByte;
    strobes.byteLow  = busAddr[0];
  end
endmodule

// File: rtl/fce_datapath.sv
module fce_datapath
  import fce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] busWrData,
  input  fceStrobes_t       strobes,
  output logic [DATA_W-1:0] busRdData,
  output logic [DATA_W-1:0] fontQ,
  output logic [CODE_W-1:0] codeQ
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] expanded [GROUPS];
  logic [DATA_W-1:0] wordSel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fontQ <= '0;
      codeQ <= '0;
    end else begin
      if (strobes.wrFont) fontQ <= busWrData;
      if (strobes.wrCode) codeQ <= busWrData[CODE_W-1:0];
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : gen_group
    for (genvar p = 0; p < PIX_PER_WORD; p++) begin : gen_pix
      assign expanded[g][p*PIX_W +: PIX_W] =
        fontQ[(GROUPS-1-g)*PIX_PER_WORD + p] ? codeQ[CODE_W-1 -: PIX_W]
                                             : codeQ[PIX_W-1:0];
    end
  end

  always_comb begin
    wordSel = '0;
    if (strobes.rdResult)    wordSel = expanded[strobes.resIdx];
    else if (strobes.rdFont) wordSel = fontQ;
    else if (strobes.rdCode) wordSel = {{(DATA_W-CODE_W){1'b0}}, codeQ};

    if (strobes.byteRd)
      busRdData = {{HALF_W{1'b0}},
                   strobes.byteLow ? wordSel[HALF_W-1:0] : wordSel[DATA_W-1:HALF_W]};
    else
      busRdData = wordSel;
  end
endmodule

// File: rtl/font_color_expander.sv
module font_color_expander
  import fce_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [15:0]       busWrData,
  input  logic              busRdByte,
  output logic [15:0]       busRdData
);
  fceStrobes_t       strobes;
  logic [DATA_W-1:0] fontQ;
  logic [CODE_W-1:0] codeQ;

  fce_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busRdByte(busRdByte),
    .strobes  (strobes)
  );

  fce_datapath i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .busWrData(busWrData),
    .strobes  (strobes),
    .busRdData(busRdData),
    .fontQ    (fontQ),
    .codeQ    (codeQ)
  );
endmodule

// File: rtl/fce_checker.sv
module fce_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [15:0]       busWrData,
  input logic              busRdByte,
  input logic [15:0]       busRdData,
  input logic [15:0]       fontQ,
  input logic [7:0]        codeQ
);
  logic [ADDR_W-1:0] wAddr;
  assign wAddr = {busAddr[ADDR_W-1:1], 1'b0};

  AST_CODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && wAddr == ADDR_W'(8'h4C)) |=> (codeQ == $past(busWrData[7:0]))); // R2

  AST_FONT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && wAddr == ADDR_W'(8'h4E)) |=> (fontQ == $past(busWrData))); // R3

  AST_GROUP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busRdByte && wAddr == ADDR_W'(8'h50) && !fontQ[15]) |-> (busRdData[15:12] == codeQ[3:0])); // R4

  AST_PIXEL_FG: assert property (@(posedge clk) disable iff (!rst_n)
    (!busRdByte && wAddr == ADDR_W'(8'h56) && fontQ[0]) |-> (busRdData[3:0] == codeQ[7:4])); // R5

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busRdByte |-> (busRdData[15:8] == 8'h00)); // R6

  AST_RESULT_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && wAddr >= ADDR_W'(8'h50) && wAddr <= ADDR_W'(8'h56)) |=> ($stable(fontQ) && $stable(codeQ))); // R7
endmodule

bind font_color_expander fce_checker #(.ADDR_W(ADDR_W)) i_fce_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .busRdByte(busRdByte),
  .busRdData(busRdData),
  .fontQ    (fontQ),
  .codeQ    (codeQ)
);

// File: tb/test_font_color_expander.sv
module test_font_color_expander;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic        busRdByte = 1'b0;
  logic [15:0] busRdData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  font_color_expander i_font_color_expander (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdByte(busRdByte), .busRdData(busRdData)
  );

  // {glyph, palette, word@50, word@52, word@54, word@56}
  localparam logic [87:0] VECS [6] = '{
    {16'hFFFF, 8'hA5, 16'hAAAA, 16'hAAAA, 16'hAAAA, 16'hAAAA},
    {16'h0000, 8'hA5, 16'h5555, 16'h5555, 16'h5555, 16'h5555},
    {16'h8421, 8'h3C, 16'h3CCC, 16'hC3CC, 16'hCC3C, 16'hCCC3},
    {16'h1E6B, 8'hF0, 16'h000F, 16'hFFF0, 16'h0FF0, 16'hF0FF},
    {16'h1248, 8'h3C, 16'hCCC3, 16'hCC3C, 16'hC3CC, 16'h3CCC},
    {16'hF00F, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0000}
  };

  function automatic logic [15:0] refExpand(logic [15:0] f, logic [7:0] c, int idx);
    logic [15:0] r;
    for (int p = 0; p < 4; p++)
      r[p*4 +: 4] = f[(3 - idx) * 4 + p] ? c[7:4] : c[3:0];
    return r;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic byteMode, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; busRdByte = byteMode;
    #2;
    d = busRdData;
    busRdByte = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    // R1: reset values
    rd(8'h4C, 1'b0, d); check("R1 palette reset", d, 16'h0000);
    rd(8'h4E, 1'b0, d); check("R1 glyph reset", d, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R4, R5
    foreach (VECS[i]) begin
      wr(8'h4E, VECS[i][87:72]);
      wr(8'h4C, {8'h00, VECS[i][71:64]});
      for (int k = 0; k < 4; k++) begin
        rd(8'h50 + 8'(2 * k), 1'b0, d);
        check("R4/R5 table", d, VECS[i][63 - 16*k -: 16]);
      end
    end

    // R2: upper data byte dropped
    wr(8'h4C, 16'hBE7D);
    rd(8'h4C, 1'b0, d); check("R2 palette readback", d, 16'h007D);
    // R3: full glyph readback
    wr(8'h4E, 16'hC3A5);
    rd(8'h4E, 1'b0, d); check("R3 glyph readback", d, 16'hC3A5);

    // R8: read right after write
    wr(8'h4E, 16'h000F);
    rd(8'h56, 1'b0, d); check("R8 immediate result", d, 16'h7777);
    wr(8'h4C, 16'h0012);
    rd(8'h56, 1'b0, d); check("R8 immediate palette", d, 16'h1111);
    rd(8'h50, 1'b0, d); check("R8 background word", d, 16'h2222);

    // R6: byte reads
    wr(8'h4E, 16'h1E6B);
    wr(8'h4C, 16'h00F0);
    rd(8'h52, 1'b1, d); check("R6 even byte", d, 16'h00FF);
    rd(8'h53, 1'b1, d); check("R6 odd byte", d, 16'h00F0);
    rd(8'h56, 1'b1, d); check("R6 even byte 56", d, 16'h00F0);
    rd(8'h57, 1'b1, d); check("R6 odd byte 57", d, 16'h00FF);
    rd(8'h4F, 1'b1, d); check("R6 odd glyph byte", d, 16'h006B);

    // R7: writes to result window ignored
    wr(8'h52, 16'hFFFF);
    wr(8'h57, 16'h5555);
    rd(8'h4E, 1'b0, d); check("R7 glyph kept", d, 16'h1E6B);
    rd(8'h4C, 1'b0, d); check("R7 palette kept", d, 16'h00F0);

    // R9: unmapped space
    rd(8'h40, 1'b0, d); check("R9 unmapped read 40", d, 16'h0000);
    rd(8'h58, 1'b0, d); check("R9 unmapped read 58", d, 16'h0000);
    wr(8'h60, 16'hAAAA);
    wr(8'h4A, 16'h1234);
    rd(8'h4E, 1'b0, d); check("R9 glyph kept", d, 16'h1E6B);
    rd(8'h4C, 1'b0, d); check("R9 palette kept", d, 16'h00F0);

    // Random patterns against the bench model: R4, R5
    for (int n = 0; n < 40; n++) begin
      logic [15:0] f;
      logic [7:0]  c;
      f = 16'($urandom);
      c = 8'($urandom);
      wr(8'h4E, f);
      wr(8'h4C, {8'h00, c});
      for (int k = 0; k < 4; k++) begin
        rd(8'h50 + 8'(2 * k), 1'b0, d);
        check("R5 random", d, refExpand(f, c, k));
      end
    end

    // R1: reset mid-run clears both registers
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    rd(8'h4E, 1'b0, d); check("R1 glyph re-reset", d, 16'h0000);
    rd(8'h4C, 1'b0, d); check("R1 palette re-reset", d, 16'h0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule